// File: doc/BRIEF.md
# PN9 Bit-Serial Whitener

This block whitens a serial bit stream in a radio modem data path. In the transmit direction, each user bit is XORed with the sum of stages 5 and 9 of a nine-stage shift register. The register takes in the scrambled bit, so the transmitted stream follows the x^9 + x^5 + 1 sequence. In the receive direction, the same tap sum is XORed onto each demodulated line bit. Here the register takes in the raw line bits, so the receiver needs no seed to match the transmitter: it falls into step by itself once nine line bits have passed. One corrupted line bit then shows up as three bad output bits.

The block advances one bit for each cycle on which the bit-clock enable is high. The result appears on the registered output one cycle later, with the same latency in both directions. When the whitening control is low, bits pass through unchanged and the shift register is held at zero. A freshly enabled register therefore starts from all zeros, and it stays there until a one arrives on the data input.

Top module: `pn9_whitener`

## Requirements
- R1: With whitening on, on each cycle with `bit_en` high, `dout` takes `din ^ s5 ^ s9` at that clock edge, where sK is the bit taken into the register K strobes earlier.
- R2: The shift register and `dout` change only on cycles with `bit_en` high (or on a clear). Each strobe shifts the register by exactly one stage.
- R3: With whitening off, each strobe loads `dout` with `din` unchanged, in either direction.
- R4: While whitening is off, the register is cleared to zero. After whitening is turned on in transmit with `din` held at 0, `dout` stays 0 until the first 1 is applied.
- R5: In receive (`rx_mode` = 1), the bit taken into the register on a strobe is `din`, the line bit.
- R6: In transmit (`rx_mode` = 0), the bit taken into the register on a strobe is the scrambled bit placed on `dout`. Feeding a transmit output stream through the receive direction returns the original data.
- R7: In receive, every output bit from the tenth strobe onward depends only on the line bits, whatever the register held beforehand.
- R8: In receive, inverting a single line bit at strobe k inverts exactly three output bits: those at strobes k, k+5 and k+9.
- R9: While `rst_n` is low, `dout` is 0 and the register is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit-clock enable; one data bit per high cycle |
| rx_mode | input | 1 | Direction: 0 transmit, 1 receive |
| whiten_on | input | 1 | 1 applies the sequence; 0 bypasses and clears the register |
| din | input | 1 | Serial input: user data (transmit) or demodulated bit (receive) |
| dout | output | 1 | Registered serial output |

## Verification
The assertions assume that `rx_mode` and `whiten_on` are held steady across each strobe. Only the data bit is expected to change from one bit period to the next. Direction and enable changes between bit periods are legal, and the shift-relation checks hold across them. The directed tasks change `rx_mode`, `whiten_on` and `din` only at falling edges, and they raise `bit_en` for one cycle at a time. Idle gaps between strobes exercise the hold property.

// File: rtl/pn9_pkg.sv
package pn9_pkg;

  localparam int unsigned PN_LEN   = 9;
  localparam int unsigned PN_TAP_A = 5;

  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } pn_dir_e;

  // Sum of the two feedback stages; stage K sits at index K-1.
  function automatic logic pn_tap(input logic [PN_LEN-1:0] st);
    return st[PN_TAP_A-1] ^ st[PN_LEN-1];
  endfunction

  // Whitened bit for one strobe.
  function automatic logic pn_mix(input logic d, input logic [PN_LEN-1:0] st,
                                  input logic on);
    return on ? (d ^ pn_tap(st)) : d;
  endfunction

  // Bit taken into stage 1: line bit on receive, scrambled bit on transmit.
  function automatic logic pn_feed(input pn_dir_e dir, input logic d,
                                   input logic mixed);
    return (dir == DIR_RX) ? d : mixed;
  endfunction

endpackage

// File: rtl/pn9_shift_reg.sv
module pn9_shift_reg #(
  parameter int unsigned LEN = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  logic           clear,
  input  logic           feed,
  output logic [LEN-1:0] state
);

  genvar gi;
  generate
    for (gi = 0; gi < LEN; gi++) begin : g_stage
      logic nxt;
      if (gi == 0) begin : g_head
        assign nxt = feed;
      end else begin : g_body
        assign nxt = state[gi-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state[gi] <= 1'b0;
        else if (clear)  state[gi] <= 1'b0;
        else if (step)   state[gi] <= nxt;
      end
    end
  endgenerate

endmodule

// File: rtl/pn9_mixer.sv
module pn9_mixer
  import pn9_pkg::*;
#(
  parameter int unsigned LEN = PN_LEN
) (
  input  logic           din,
  input  logic [LEN-1:0] state,
  input  pn_dir_e        dir,
  input  logic           on,
  output logic           tap_bit,
  output logic           mixed_bit,
  output logic           feed_bit
);

  always_comb begin
    tap_bit   = pn_tap(state);
    mixed_bit = pn_mix(din, state, on);
    feed_bit  = pn_feed(dir, din, mixed_bit);
  end

endmodule

// File: rtl/pn9_out_reg.sv
module pn9_out_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (step) q <= d;
  end

endmodule

// File: rtl/pn9_whitener.sv
module pn9_whitener
  import pn9_pkg::*;
#(
  parameter int unsigned LEN   = PN_LEN,
  parameter int unsigned TAP_A = PN_TAP_A
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_mode,
  input  logic whiten_on,
  input  logic din,
  output logic dout
);

  localparam int unsigned TOP_IDX = LEN - 1;

  pn_dir_e        dir;
  logic [LEN-1:0] sr_q;
  logic           tap_bit;
  logic           mixed_bit;
  logic           feed_bit;
  logic           sr_clear;
  logic           strobe;

  assign dir      = pn_dir_e'(rx_mode);
  assign sr_clear = ~whiten_on;
  assign strobe   = bit_en;

  pn9_mixer #(.LEN(LEN)) u_mix (
    .din       (din),
    .state     (sr_q),
    .dir       (dir),
    .on        (whiten_on),
    .tap_bit   (tap_bit),
    .mixed_bit (mixed_bit),
    .feed_bit  (feed_bit)
  );

  pn9_shift_reg #(.LEN(LEN)) u_sr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (strobe),
    .clear (sr_clear),
    .feed  (feed_bit),
    .state (sr_q)
  );

  pn9_out_reg u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (strobe),
    .d     (mixed_bit),
    .q     (dout)
  );

  initial begin
    if (TAP_A != PN_TAP_A || LEN != PN_LEN || TOP_IDX != LEN - 1)
      $error("pn9_whitener: taps are fixed by pn9_pkg");
  end

endmodule

// File: rtl/pn9_whitener_chk.sv
module pn9_whitener_chk #(
  parameter int unsigned LEN   = 9,
  parameter int unsigned TAP_A = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bit_en,
  input logic           rx_mode,
  input logic           whiten_on,
  input logic           din,
  input logic           dout,
  input logic [LEN-1:0] sr_q,
  input logic           tap_bit
);

  AST_OUT_MIX: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && whiten_on) |=> (dout == ($past(din) ^ $past(sr_q[TAP_A-1]) ^ $past(sr_q[LEN-1])))); // R1

  AST_TAP_USED: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && whiten_on) |=> (dout == ($past(din) ^ $past(tap_bit)))); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && whiten_on) |=> ($stable(sr_q) && $stable(dout))); // R2

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && whiten_on) |=> (sr_q[LEN-1:1] == $past(sr_q[LEN-2:0]))); // R2

  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !whiten_on) |=> (dout == $past(din))); // R3

  AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!whiten_on) |=> (sr_q == '0)); // R4

  AST_RX_FEED: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && whiten_on && rx_mode) |=> (sr_q[0] == $past(din))); // R5

  AST_TX_FEED: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && whiten_on && !rx_mode) |=> (sr_q[0] == dout)); // R6

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_ZERO: assert (dout == 1'b0 && sr_q == '0); // R9
    end
  end

endmodule

bind pn9_whitener pn9_whitener_chk #(.LEN(LEN), .TAP_A(TAP_A)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_en    (bit_en),
  .rx_mode   (rx_mode),
  .whiten_on (whiten_on),
  .din       (din),
  .dout      (dout),
  .sr_q      (sr_q),
  .tap_bit   (tap_bit)
);

// File: tb/test_pn9_whitener.sv
`timescale 1ns/1ps
module test_pn9_whitener;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic rx_mode = 1'b0;
  logic whiten_on = 1'b0;
  logic din = 1'b0;
  logic dout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench reference: hist[k] is the bit fed in k strobes ago (1..9).
  logic hist [1:9];
  logic [31:0] rng = 32'h1234_5678;

  always #2.5 clk = ~clk;

  pn9_whitener i_pn9_whitener (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_mode(rx_mode),
    .whiten_on(whiten_on), .din(din), .dout(dout)
  );

  function automatic logic next_rand();
    rng = rng * 32'd1103515245 + 32'd12345;
    return rng[16];
  endfunction

  task automatic model_clear();
    for (int k = 1; k <= 9; k++) hist[k] = 1'b0;
  endtask

  // Reference step: returns the output bit, then pushes the fed bit.
  task automatic model_step(input logic d, input logic rx, output logic o);
    o = d ^ hist[5] ^ hist[9];
    for (int k = 9; k >= 2; k--) hist[k] = hist[k-1];
    hist[1] = rx ? d : o;
  endtask

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0b exp=%0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic strobe(input logic d, output logic got);
    @(negedge clk);
    din = d;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    got = dout;
  endtask

  task automatic set_mode(input logic on, input logic rx);
    @(negedge clk);
    whiten_on = on;
    rx_mode = rx;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic g;
    int ones = 0;
    check("R9 dout in reset", dout, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    set_mode(1'b1, 1'b0);
    for (int i = 0; i < 20; i++) begin
      strobe(1'b0, g);
      if (g) ones++;
    end
    check("R4 R9 zero register, zero data stays zero", ones != 0, 1'b0);
  endtask

  task automatic t_tx_seq();
    logic g, e;
    int bad = 0;
    model_clear();
    set_mode(1'b0, 1'b0);
    set_mode(1'b1, 1'b0);
    strobe(1'b1, g);
    model_step(1'b1, 1'b0, e);
    check("R4 first one starts sequence", g, e);
    for (int i = 0; i < 40; i++) begin
      strobe(1'b0, g);
      model_step(1'b0, 1'b0, e);
      if (g !== e) bad++;
    end
    check("R1 R6 TX sequence from single one", bad != 0, 1'b0);
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      logic d;
      d = next_rand();
      strobe(d, g);
      model_step(d, 1'b0, e);
      if (g !== e) bad++;
    end
    check("R1 R6 TX sequence with random data", bad != 0, 1'b0);
  endtask

  task automatic t_gap();
    logic g, e, held;
    strobe(1'b1, g);
    model_step(1'b1, 1'b0, e);
    check("R1 before gap", g, e);
    held = dout;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      din = ~din;
      check("R2 dout stable without strobe", dout, held);
    end
    strobe(1'b0, g);
    model_step(1'b0, 1'b0, e);
    check("R2 register unchanged across gap", g, e);
  endtask

  task automatic t_bypass();
    logic g;
    int bad = 0;
    set_mode(1'b0, 1'b0);
    for (int i = 0; i < 16; i++) begin
      logic d;
      d = next_rand();
      strobe(d, g);
      if (g !== d) bad++;
    end
    set_mode(1'b0, 1'b1);
    for (int i = 0; i < 16; i++) begin
      logic d;
      d = next_rand();
      strobe(d, g);
      if (g !== d) bad++;
    end
    check("R3 bypass both directions", bad != 0, 1'b0);
    set_mode(1'b1, 1'b0);
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      strobe(1'b0, g);
      if (g) bad++;
    end
    check("R4 off cleared register", bad != 0, 1'b0);
  endtask

  task automatic t_rx();
    logic txm [1:9];
    logic g, e, line, d;
    int bad_model = 0, bad_data = 0;
    for (int k = 1; k <= 9; k++) txm[k] = 1'b0;
    set_mode(1'b0, 1'b1);
    set_mode(1'b1, 1'b1);
    model_clear();
    for (int i = 0; i < 80; i++) begin
      d = (i == 0) ? 1'b1 : next_rand();
      line = d ^ txm[5] ^ txm[9];
      for (int k = 9; k >= 2; k--) txm[k] = txm[k-1];
      txm[1] = line;
      strobe(line, g);
      model_step(line, 1'b1, e);
      if (g !== e) bad_model++;
      if (g !== d) bad_data++;
    end
    check("R5 RX output vs reference", bad_model != 0, 1'b0);
    check("R6 TX then RX recovers data", bad_data != 0, 1'b0);
  endtask

  task automatic t_resync();
    logic txm [1:9];
    logic g, line, d;
    int bad = 0;
    for (int k = 1; k <= 9; k++) txm[k] = (k % 2 == 1);
    set_mode(1'b1, 1'b1);
    for (int i = 0; i < 7; i++) strobe(next_rand(), g);
    for (int i = 0; i < 50; i++) begin
      d = next_rand();
      line = d ^ txm[5] ^ txm[9];
      for (int k = 9; k >= 2; k--) txm[k] = txm[k-1];
      txm[1] = line;
      strobe(line, g);
      if (i >= 9 && g !== d) bad++;
    end
    check("R7 RX resynchronizes after 9 bits", bad != 0, 1'b0);
  endtask

  task automatic t_error();
    logic txm [1:9];
    logic g, line, d;
    int bad = 0, pos_ok = 1;
    for (int k = 1; k <= 9; k++) txm[k] = 1'b0;
    set_mode(1'b0, 1'b1);
    set_mode(1'b1, 1'b1);
    for (int i = 0; i < 50; i++) begin
      d = (i == 0) ? 1'b1 : next_rand();
      line = d ^ txm[5] ^ txm[9];
      for (int k = 9; k >= 2; k--) txm[k] = txm[k-1];
      txm[1] = line;
      strobe((i == 20) ? ~line : line, g);
      if (g !== d) begin
        bad++;
        if (i != 20 && i != 25 && i != 29) pos_ok = 0;
      end
    end
    check("R8 single error gives three errors", bad == 3, 1'b1);
    check("R8 error positions k, k+5, k+9", pos_ok == 1, 1'b1);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_tx_seq();
    t_gap();
    t_bypass();
    t_rx();
    t_resync();
    t_error();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule